// File: doc/BRIEF.md
# Priority Interrupt Presenter

This block sits next to one processor and decides which single interrupt that processor sees. Source controllers send it requests made of a 24-bit source number and an 8-bit priority. Each request is either latched as the pending interrupt or bounced back to its source with a reject pulse. A latched interrupt drives the processor's interrupt line until software takes it or it is withdrawn. Smaller priority numbers win, and 0xFF means "none".

Software reaches the block through a one-operation-per-cycle register port. The operations are accept, poll, end-of-interrupt, current-priority write and inter-processor-interrupt (IPI) priority write. The state is a 32-bit interrupt word, a pending priority and an IPI priority. The interrupt word carries the current processor priority in bits 31:24 and the pending source number in bits 23:0, where a source number of 0 means nothing is pending. A more favoured arrival displaces the pending interrupt. A displaced interrupt goes back to its source only if it came from outside. End-of-interrupt and resend notices go to the sources as one-cycle pulses.

Top module: `intc_presenter`

## Requirements
- R1: After reset `irq_out` is low, a poll returns an interrupt word of 0, and `rd_ipi` reads 0xFF. Internally the pending priority is 0xFF.
- R2: A request whose priority is not below the current priority is rejected. A request is also rejected when a source is pending at a priority less than or equal to the request's priority. A rejected request produces `rej_valid` with `rej_src` equal to the request source one cycle later, and nothing else changes.
- R3: A request that is not rejected replaces the pending interrupt, sets the pending priority and marks the interrupt as external. If the displaced interrupt was external, it is rejected back to its source in the same pulse cycle. A displaced IPI is dropped silently.
- R4: `irq_out` is registered. It is high exactly when the source field of the interrupt word is nonzero.
- R5: Accept (op code 1) returns the whole interrupt word on `rd_word`, with `rd_valid` one cycle later. It then loads the current priority from the pending priority, clears the source field, sets the pending priority to 0xFF and lowers `irq_out`.
- R6: An IPI-priority write (op code 5, value in bits 7:0) below the current priority runs an IPI check. The check does nothing if a source is pending at a priority less than or equal to the new value. Otherwise it rejects any external pending source and latches source number 2 at the new priority, with `irq_out` high.
- R7: An IPI-priority write that is not below the current priority only stores the value, which appears on `rd_ipi` of later reads.
- R8: A current-priority write (op code 4, value in bits 31:24) that lowers the value drops a pending interrupt whose priority is greater than or equal to the new value. Dropping clears the source field, sets the pending priority to 0xFF and lowers `irq_out`. The dropped source is rejected if it was external.
- R9: A current-priority write that does not lower the value, made while nothing is pending, pulses `resend`. In the same step it latches the IPI if the IPI priority is below the new current priority.
- R10: End-of-interrupt (op code 3) loads the current priority from bits 31:24 and pulses `eoi_valid` with `eoi_src` equal to bits 23:0. If nothing is pending, it also performs the resend step of R9.
- R11: Poll (op code 2) returns the interrupt word and the IPI priority and changes no state. Op code 0 and codes 6 and 7 change nothing.
- R12: `req_ready` is low whenever `op_valid` is high. A request presented in such a cycle is not taken and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request from a source controller |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requested priority |
| req_ready | output | 1 | Request is taken this cycle |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 3 | Operation: 1 accept, 2 poll, 3 EOI, 4 current priority, 5 IPI priority |
| op_wdata | input | 32 | Write data for EOI and priority writes |
| rd_valid | output | 1 | Read result valid |
| rd_word | output | 32 | Interrupt word returned by accept or poll |
| rd_ipi | output | 8 | IPI priority returned with a read |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to sources |
| rej_src | output | 24 | Source number being rejected |
| eoi_valid | output | 1 | End-of-interrupt pulse to sources |
| eoi_src | output | 24 | Source number being ended |
| resend | output | 1 | Resend request pulse to sources |

## Verification
Each result of this block is due exactly one clock after the edge that samples the operation or request. This holds for the read word, the reject, EOI and resend pulses, and the new level of `irq_out`. The exception is `req_ready`, which follows `op_valid` within the same cycle. The bench drives inputs shortly after each rising edge and updates its reference model on that same rising edge. It compares all outputs at the falling edge that follows, so every expected value lines up with the single register stage. Pulse payloads are compared only while their valid is high.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_ACCEPT = 3'd1,
      OP_POLL   = 3'd2,
      OP_EOI    = 3'd3,
      OP_SETCUR = 3'd4,
      OP_SETIPI = 3'd5
   } ipr_op_e;
endpackage

// File: rtl/ipr_req_judge.sv
// Decides whether an incoming external request may replace the pending one.
module ipr_req_judge #(
   parameter int PW = 8
) (
   input  logic [PW-1:0] cur_prio,
   input  logic          pend_valid,
   input  logic [PW-1:0] pend_prio,
   input  logic [PW-1:0] in_prio,
   output logic          take
);
   always_comb take = (in_prio < cur_prio) && !(pend_valid && (pend_prio <= in_prio));
endmodule

// File: rtl/ipr_ipi_judge.sv
// IPI check: the IPI is presented unless something at least as favoured waits.
module ipr_ipi_judge #(
   parameter int PW = 8
) (
   input  logic          pend_valid,
   input  logic [PW-1:0] pend_prio,
   input  logic [PW-1:0] ipi_prio,
   output logic          take
);
   always_comb take = !(pend_valid && (pend_prio <= ipi_prio));
endmodule

// File: rtl/intc_presenter.sv
module intc_presenter #(
   parameter int SW      = 24,
   parameter int PW      = 8,
   parameter int IPI_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [SW-1:0]    req_src,
   input  logic [PW-1:0]    req_prio,
   output logic             req_ready,
   input  logic             op_valid,
   input  logic [2:0]       op_code,
   input  logic [SW+PW-1:0] op_wdata,
   output logic             rd_valid,
   output logic [SW+PW-1:0] rd_word,
   output logic [PW-1:0]    rd_ipi,
   output logic             irq_out,
   output logic             rej_valid,
   output logic [SW-1:0]    rej_src,
   output logic             eoi_valid,
   output logic [SW-1:0]    eoi_src,
   output logic             resend
);
   import ipr_pkg::*;

   localparam int WW = SW + PW;
   localparam logic [PW-1:0] PRIO_NONE = {PW{1'b1}};
   localparam logic [SW-1:0] IPI_NUM   = SW'(IPI_SRC);

   generate
      if (IPI_SRC <= 0 || IPI_SRC >= (1 << SW)) begin : g_bad_ipi
         $error("IPI_SRC must be a nonzero source number that fits in SW bits");
      end
      if (PW < 2 || SW < 2) begin : g_bad_width
         $error("PW and SW must each be at least 2");
      end
   endgenerate

   // architectural state
   logic [PW-1:0] cur_q, pp_q, ipi_q;
   logic [SW-1:0] src_q;
   logic          ext_q, irq_q;
   logic [PW-1:0] n_cur, n_pp, n_ipi;
   logic [SW-1:0] n_src;
   logic          n_ext, n_irq;

   // output registers
   logic          n_rej_v, n_eoi_v, n_rs, n_rd_v;
   logic [SW-1:0] n_rej_src, n_eoi_src;
   logic [WW-1:0] n_rd_word;
   logic [PW-1:0] n_rd_ipi;

   logic          pend, req_take, ipi_take, resend_go;
   logic [PW-1:0] wr_cur, wr_ipi;
   ipr_op_e       op;

   assign pend      = (src_q != '0);
   assign wr_cur    = op_wdata[WW-1 -: PW];
   assign wr_ipi    = op_wdata[PW-1:0];
   assign op        = ipr_op_e'(op_code);
   assign req_ready = !op_valid;

   ipr_req_judge #(.PW(PW)) u_req (
      .cur_prio(cur_q), .pend_valid(pend), .pend_prio(pp_q),
      .in_prio(req_prio), .take(req_take));

   ipr_ipi_judge #(.PW(PW)) u_ipi (
      .pend_valid(pend), .pend_prio(pp_q), .ipi_prio(wr_ipi), .take(ipi_take));

   always_comb begin
      n_cur = cur_q;   n_src = src_q;   n_pp = pp_q;
      n_ipi = ipi_q;   n_ext = ext_q;   n_irq = irq_q;
      n_rej_v = 1'b0;  n_rej_src = src_q;
      n_eoi_v = 1'b0;  n_eoi_src = op_wdata[SW-1:0];
      n_rs = 1'b0;     n_rd_v = 1'b0;
      n_rd_word = {cur_q, src_q};
      n_rd_ipi  = ipi_q;
      resend_go = 1'b0;
      if (op_valid) begin
         unique case (op)
            OP_ACCEPT: begin
               n_rd_v = 1'b1;
               n_irq  = 1'b0;
               n_cur  = pp_q;
               n_src  = '0;
               n_pp   = PRIO_NONE;
               n_ext  = 1'b0;
            end
            OP_POLL: n_rd_v = 1'b1;
            OP_EOI: begin
               n_cur     = wr_cur;
               n_eoi_v   = 1'b1;
               resend_go = !pend;
            end
            OP_SETCUR: begin
               n_cur = wr_cur;
               if (wr_cur < cur_q) begin
                  if (pend && (wr_cur <= pp_q)) begin
                     n_rej_v = ext_q;
                     n_src   = '0;
                     n_pp    = PRIO_NONE;
                     n_irq   = 1'b0;
                     n_ext   = 1'b0;
                  end
               end else begin
                  resend_go = !pend;
               end
            end
            OP_SETIPI: begin
               n_ipi = wr_ipi;
               if ((wr_ipi < cur_q) && ipi_take) begin
                  n_rej_v = pend && ext_q;
                  n_src   = IPI_NUM;
                  n_pp    = wr_ipi;
                  n_ext   = 1'b0;
                  n_irq   = 1'b1;
               end
            end
            default: ;
         endcase
      end else if (req_valid) begin
         if (!req_take) begin
            n_rej_v   = 1'b1;
            n_rej_src = req_src;
         end else begin
            n_rej_v = pend && ext_q;
            n_src   = req_src;
            n_pp    = req_prio;
            n_ext   = 1'b1;
            n_irq   = 1'b1;
         end
      end
      // resend step: nothing is pending here, so the IPI always wins if favoured enough
      if (resend_go) begin
         n_rs = 1'b1;
         if (ipi_q < n_cur) begin
            n_src = IPI_NUM;
            n_pp  = ipi_q;
            n_ext = 1'b0;
            n_irq = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= '0;
         src_q     <= '0;
         pp_q      <= PRIO_NONE;
         ipi_q     <= PRIO_NONE;
         ext_q     <= 1'b0;
         irq_q     <= 1'b0;
         rej_valid <= 1'b0;
         rej_src   <= '0;
         eoi_valid <= 1'b0;
         eoi_src   <= '0;
         resend    <= 1'b0;
         rd_valid  <= 1'b0;
         rd_word   <= '0;
         rd_ipi    <= PRIO_NONE;
      end else begin
         cur_q     <= n_cur;
         src_q     <= n_src;
         pp_q      <= n_pp;
         ipi_q     <= n_ipi;
         ext_q     <= n_ext;
         irq_q     <= n_irq;
         rej_valid <= n_rej_v;
         rej_src   <= n_rej_src;
         eoi_valid <= n_eoi_v;
         eoi_src   <= n_eoi_src;
         resend    <= n_rs;
         rd_valid  <= n_rd_v;
         if (n_rd_v) begin
            rd_word <= n_rd_word;
            rd_ipi  <= n_rd_ipi;
         end
      end
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/ipr_checker.sv
module ipr_checker #(
   parameter int SW = 24,
   parameter int PW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             op_valid,
   input logic [2:0]       op_code,
   input logic [SW+PW-1:0] op_wdata,
   input logic             irq_out,
   input logic             rej_valid,
   input logic             eoi_valid,
   input logic [SW-1:0]    eoi_src,
   input logic [SW-1:0]    src_q,
   input logic [PW-1:0]    cur_q
);
   p_line_tracks_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (src_q != '0));

   p_reject_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid |-> $past(req_valid || op_valid));

   p_accept_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd1) |=> (!irq_out && src_q == '0));

   p_poll_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd2) |=> ($stable(src_q) && $stable(cur_q) && $stable(irq_out) && !rej_valid));

   p_eoi_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd3) |=> (eoi_valid && eoi_src == $past(op_wdata[SW-1:0])));

   p_eoi_only_from_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid |-> $past(op_valid && op_code == 3'd3));
endmodule

bind intc_presenter ipr_checker #(.SW(SW), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_valid(op_valid),
   .op_code(op_code), .op_wdata(op_wdata), .irq_out(irq_out),
   .rej_valid(rej_valid), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
   .src_q(src_q), .cur_q(cur_q));

// File: tb/sim_intc_presenter.sv
module sim_intc_presenter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_src = '0;
   logic [7:0]  req_prio = '0;
   logic        req_ready;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [31:0] op_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_word;
   logic [7:0]  rd_ipi;
   logic        irq_out, rej_valid, eoi_valid, resend;
   logic [23:0] rej_src, eoi_src;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10ns clk = ~clk;   // 50 MHz

   intc_presenter u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
      .req_prio(req_prio), .req_ready(req_ready), .op_valid(op_valid),
      .op_code(op_code), .op_wdata(op_wdata), .rd_valid(rd_valid),
      .rd_word(rd_word), .rd_ipi(rd_ipi), .irq_out(irq_out),
      .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid),
      .eoi_src(eoi_src), .resend(resend));

   // ---------------- behavioural reference ----------------
   logic [7:0]  m_cur, m_pp, m_ipi;
   logic [23:0] m_src;
   logic        m_ext;
   logic        e_irq, e_rej_v, e_eoi_v, e_rs, e_rd_v;
   logic [23:0] e_rej_src, e_eoi_src;
   logic [31:0] e_rd_word;
   logic [7:0]  e_rd_ipi;

   function automatic void present_ipi(input logic [7:0] p);
      m_src = 24'd2; m_pp = p; m_ext = 1'b0; e_irq = 1'b1;
   endfunction

   always @(posedge clk) begin
      logic [7:0] wc, wi;
      logic       rsg;
      if (!rst_n) begin
         m_cur = 8'h00; m_src = '0; m_pp = 8'hFF; m_ipi = 8'hFF; m_ext = 1'b0;
         e_irq = 1'b0; e_rej_v = 1'b0; e_eoi_v = 1'b0; e_rs = 1'b0; e_rd_v = 1'b0;
         e_rej_src = '0; e_eoi_src = '0; e_rd_word = '0; e_rd_ipi = 8'hFF;
      end else begin
         e_rej_v = 1'b0; e_eoi_v = 1'b0; e_rs = 1'b0; e_rd_v = 1'b0; rsg = 1'b0;
         wc = op_wdata[31:24];
         wi = op_wdata[7:0];
         if (op_valid) begin
            case (op_code)
               3'd1: begin
                  e_rd_v = 1'b1; e_rd_word = {m_cur, m_src}; e_rd_ipi = m_ipi;
                  m_cur = m_pp; m_src = '0; m_pp = 8'hFF; m_ext = 1'b0; e_irq = 1'b0;
               end
               3'd2: begin
                  e_rd_v = 1'b1; e_rd_word = {m_cur, m_src}; e_rd_ipi = m_ipi;
               end
               3'd3: begin
                  m_cur = wc; e_eoi_v = 1'b1; e_eoi_src = op_wdata[23:0];
                  rsg = (m_src == 0);
               end
               3'd4: begin
                  if (wc < m_cur) begin
                     if (m_src != 0 && wc <= m_pp) begin
                        if (m_ext) begin e_rej_v = 1'b1; e_rej_src = m_src; end
                        m_src = '0; m_pp = 8'hFF; m_ext = 1'b0; e_irq = 1'b0;
                     end
                  end else rsg = (m_src == 0);
                  m_cur = wc;
               end
               3'd5: begin
                  m_ipi = wi;
                  if (wi < m_cur && !(m_src != 0 && m_pp <= wi)) begin
                     if (m_src != 0 && m_ext) begin e_rej_v = 1'b1; e_rej_src = m_src; end
                     present_ipi(wi);
                  end
               end
               default: ;
            endcase
         end else if (req_valid) begin
            if (req_prio >= m_cur || (m_src != 0 && m_pp <= req_prio)) begin
               e_rej_v = 1'b1; e_rej_src = req_src;
            end else begin
               if (m_src != 0 && m_ext) begin e_rej_v = 1'b1; e_rej_src = m_src; end
               m_src = req_src; m_pp = req_prio; m_ext = 1'b1; e_irq = 1'b1;
            end
         end
         if (rsg) begin
            e_rs = 1'b1;
            if (m_ipi < m_cur) present_ipi(m_ipi);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference, at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 irq_out", {31'd0, irq_out}, {31'd0, e_irq});
         chk("R12 req_ready", {31'd0, req_ready}, {31'd0, !op_valid});
         chk("R2 rej_valid", {31'd0, rej_valid}, {31'd0, e_rej_v});
         if (e_rej_v) chk("R3 rej_src", {8'd0, rej_src}, {8'd0, e_rej_src});
         chk("R10 eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi_v});
         if (e_eoi_v) chk("R10 eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
         chk("R9 resend", {31'd0, resend}, {31'd0, e_rs});
         chk("R11 rd_valid", {31'd0, rd_valid}, {31'd0, e_rd_v});
         if (e_rd_v) begin
            chk("R5 rd_word", rd_word, e_rd_word);
            chk("R7 rd_ipi", {24'd0, rd_ipi}, {24'd0, e_rd_ipi});
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input logic ov, input logic [2:0] oc, input logic [31:0] ow,
                      input logic rv, input logic [23:0] rs, input logic [7:0] rp);
      @(posedge clk);
      #3ns;
      op_valid = ov; op_code = oc; op_wdata = ow;
      req_valid = rv; req_src = rs; req_prio = rp;
   endtask

   task automatic idle();
      cyc(1'b0, 3'd0, 32'd0, 1'b0, 24'd0, 8'd0);
   endtask

   task automatic op(input logic [2:0] oc, input logic [31:0] ow);
      cyc(1'b1, oc, ow, 1'b0, 24'd0, 8'd0);
      idle();
   endtask

   task automatic req(input logic [23:0] s, input logic [7:0] p);
      cyc(1'b0, 3'd0, 32'd0, 1'b1, s, p);
      idle();
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3ns rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
      op(3'd2, 32'd0);
      chk("R1 poll word", rd_word, 32'd0);
      chk("R1 poll ipi", {24'd0, rd_ipi}, 32'hFF);
      // R2 current priority 0 rejects everything
      req(24'd5, 8'd3);
      chk("R2 reject at cur 0", {7'd0, rej_valid, rej_src}, {8'h01, 24'd5});
      // R9 raise current priority with nothing pending
      op(3'd4, 32'h1000_0000);
      chk("R9 resend pulse", {31'd0, resend}, 32'd1);
      chk("R9 no ipi", {31'd0, irq_out}, 32'd0);
      // R4 latch
      req(24'd7, 8'd6);
      chk("R4 line up", {31'd0, irq_out}, 32'd1);
      // R2 equal priority rejected
      req(24'd9, 8'd6);
      chk("R2 equal pending", {7'd0, rej_valid, rej_src}, {8'h01, 24'd9});
      // R3 displacement of external
      req(24'd11, 8'd4);
      chk("R3 displaced reject", {7'd0, rej_valid, rej_src}, {8'h01, 24'd7});
      // R6 IPI blocked by more favoured pending
      op(3'd5, 32'd8);
      op(3'd2, 32'd0);
      chk("R6 ipi blocked", rd_word, 32'h1000_000B);
      // R6 IPI wins, rejects external
      op(3'd5, 32'd2);
      chk("R6 ipi rejects ext", {7'd0, rej_valid, rej_src}, {8'h01, 24'd11});
      op(3'd2, 32'd0);
      chk("R6 ipi source", rd_word, 32'h1000_0002);
      // R3 IPI displaced silently
      req(24'd13, 8'd1);
      chk("R3 ipi silent", {31'd0, rej_valid}, 32'd0);
      // R5 accept
      op(3'd1, 32'd0);
      chk("R5 accept word", rd_word, 32'h1000_000D);
      chk("R5 line down", {31'd0, irq_out}, 32'd0);
      op(3'd2, 32'd0);
      chk("R5 new cur", rd_word, 32'h0100_0000);
      // R7 IPI write not below current
      op(3'd5, 32'h30);
      chk("R7 stored only", {31'd0, irq_out}, 32'd0);
      // R10 EOI with resend presenting IPI
      op(3'd3, 32'hFF00_000D);
      chk("R10 eoi", {7'd0, eoi_valid, eoi_src}, {8'h01, 24'd13});
      chk("R10 resend ipi", {30'd0, resend, irq_out}, 32'd3);
      // R8 lowering drops IPI silently
      op(3'd4, 32'h2000_0000);
      chk("R8 drop ipi", {30'd0, rej_valid, irq_out}, 32'd0);
      op(3'd4, 32'h4000_0000);
      req(24'd15, 8'h10);
      op(3'd4, 32'h0500_0000);
      chk("R8 drop ext", {6'd0, irq_out, rej_valid, rej_src}, {8'h01, 24'd15});
      // R12 request ignored during operation
      cyc(1'b1, 3'd2, 32'd0, 1'b1, 24'd20, 8'd0);
      idle();
      chk("R12 request not taken", {31'd0, irq_out}, 32'd0);
      chk("R11 poll after", rd_word, 32'h0500_0000);
      op(3'd6, 32'hFFFF_FFFF);
      op(3'd2, 32'd0);
      chk("R11 unused code", rd_word, 32'h0500_0000);
      // randomized traffic checked against the model each cycle
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] p;
         logic [2:0] c;
         p = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 15));
         c = 3'($urandom_range(0, 7));
         case ($urandom_range(0, 3))
            0: cyc(1'b0, 3'd0, 32'd0, 1'b1, 24'($urandom_range(3, 40)), p);
            1: cyc(1'b1, c, {p, 16'd0, p}, 1'b0, 24'd0, 8'd0);
            2: cyc(1'b1, c, {p, 24'($urandom_range(3, 40))}, 1'b1,
                   24'($urandom_range(3, 40)), p);
            default: idle();
         endcase
      end
      idle();
      idle();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule